// File: doc/BRIEF.md
# Key-Protected Memory Configuration Registers

This block is a small register window in the control space of an SDRAM controller. It sits on a 32-bit APB-style peripheral bus. It holds two words: a protection key word and a memory configuration word. The configuration word records how much memory is fitted. Firmware reads it at boot to size its memory map.

The configuration word can change only while the key word holds one particular 32-bit unlock value. Storing any other value in the key word locks the block again. At reset the configuration word is loaded from a parameter that carries the installed size. The size can use either of two encoding generations, and the newer one is marked by a flag bit. The block decodes that word into a size in megabytes and reports whether it is locked.

Every access completes in one cycle. Accesses that are rejected raise the bus error flag. These are writes made while the block is locked, accesses outside the two words, and accesses that are not aligned full words.

Top module: `memcfg_keyguard`

## Requirements
- R1: The key word at byte offset 0x00 accepts every valid write whatever the lock state, and a read of it returns the last value written.
- R2: `lockedO` is low exactly when the stored key equals 0xFC600309. Writing any other value to the key word sets it high from the next cycle.
- R3: While locked, a write to the configuration word at offset 0x04 raises `pslverr` and leaves the word and `memSizeMb` unchanged.
- R4: After reset the key word reads 0, the block is locked, and the configuration word reads `CFG_RESET`. The default is 0x00000002, which is 256 MB.
- R5: When bit 28 of the configuration word is 0, bits [1:0] values 0, 1, 2 and 3 give `memSizeMb` of 64, 128, 256 and 512.
- R6: When bit 28 of the configuration word is 1, bits [1:0] values 0, 1, 2 and 3 give `memSizeMb` of 128, 256, 512 and 1024.
- R7: Aligned accesses at offsets 0x08 to 0xFFC raise `pslverr`. Reads there return 0 and writes there change nothing.
- R8: An access whose `paddr[1:0]` is not 0, or a write whose `pstrb` is not 4'hF, raises `pslverr`. It changes no state, and a read of this kind returns 0.
- R9: `pready` is always high, and `prdata` and `pslverr` are valid in the access phase of every transfer.
- R10: While unlocked, a write to the configuration word stores all 32 bits. The new value is visible to reads and on `memSizeMb` from the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte offset in the 4 KB window |
| pwdata | input | 32 | Write data, little-endian |
| pstrb | input | 4 | Byte strobes; writes need all four set |
| pready | output | 1 | Transfer complete (always 1) |
| prdata | output | 32 | Read data |
| pslverr | output | 1 | Access rejected |
| lockedO | output | 1 | High while the key is not the unlock value |
| memSizeMb | output | SIZE_W (16) | Decoded memory size in MB |

## Verification
The lock decision and a key update can coincide. A key write takes effect at the same edge that ends the access, so the lock gating for any configuration write must use the key as it stood before that edge. The bench provokes this with back-to-back transfers. In one sequence it unlocks and then writes the configuration word. In another it writes a near-miss key and then writes the configuration word. It judges each configuration write by its error flag and by the decoded size in the following cycle. In a rejected write, the error flag and the suppression of the update fall in the same cycle. Both are checked for every locked, misaligned, partial-strobe and out-of-range write.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

  // Number of implemented 32-bit words and their word indices
  localparam int NUM_WORDS    = 2;
  localparam int KEY_IDX      = 0;
  localparam int CFG_IDX      = 1;
  localparam int DATA_W       = 32;
  localparam int STRB_W       = DATA_W / 8;

  // Unlock value held in the key word
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hFC60_0309;

  // Configuration word fields the size decoder reads
  localparam int GEN_BIT      = 28;
  localparam int SIZE_FIELD_W = 2;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic [NUM_WORDS-1:0] weVec;   // per-word write enable, already lock-gated
    logic [NUM_WORDS-1:0] rdSel;   // one-hot read select, zero for rejected reads
  } strobe_t;

endpackage

// File: rtl/memcfg_ctrl.sv
module memcfg_ctrl
  import memcfg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [STRB_W-1:0] pstrb,
  input  logic              lockedI,
  output strobe_t           strobes,
  output logic              pready,
  output logic              pslverr
);

  localparam int IDX_W = ADDR_W - 2;

  logic             access;
  logic             aligned;
  logic             fullWord;
  logic             formatOk;
  logic             inRange;
  logic             lockReject;
  logic [IDX_W-1:0] wordIdx;
  logic [NUM_WORDS-1:0] hit;

  assign access   = psel & penable;
  assign aligned  = (paddr[1:0] == 2'b00);
  assign fullWord = ~pwrite | (&pstrb);
  assign formatOk = aligned & fullWord;
  assign wordIdx  = paddr[ADDR_W-1:2];
  assign inRange  = (wordIdx < IDX_W'(NUM_WORDS));

  // Per-word decode and lock gating; only the key word bypasses the lock
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam bit IsKey = (i == KEY_IDX);
    assign hit[i] = access & formatOk & (wordIdx == IDX_W'(i));
    if (IsKey) begin : g_key
      assign strobes.weVec[i] = hit[i] & pwrite;
    end else begin : g_prot
      assign strobes.weVec[i] = hit[i] & pwrite & ~lockedI;
    end
    assign strobes.rdSel[i] = hit[i] & ~pwrite;
  end

  // A write that hit a protected word while locked
  always_comb begin
    lockReject = 1'b0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (i != KEY_IDX && hit[i] && pwrite && lockedI) lockReject = 1'b1;
    end
  end

  assign pready  = 1'b1;
  assign pslverr = access & (~formatOk | ~inRange | lockReject);

endmodule

// File: rtl/memcfg_regs.sv
module memcfg_regs
  import memcfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] CFG_RESET = 32'h0000_0002
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobes,
  input  logic [DATA_W-1:0]       pwdata,
  output logic [DATA_W-1:0]       prdata,
  output logic                    lockedO,
  output logic                    genFlag,
  output logic [SIZE_FIELD_W-1:0] sizeField
);

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_store
    localparam logic [DATA_W-1:0] RstVal = (i == CFG_IDX) ? CFG_RESET : '0;
    always_ff @(posedge clk) begin
      if (!rstN)                 words[i] <= RstVal;
      else if (strobes.weVec[i]) words[i] <= pwdata;
    end
  end

  // AND-OR read mux; no select means zero
  always_comb begin
    prdata = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (strobes.rdSel[i]) prdata = prdata | words[i];
    end
  end

  assign lockedO   = (words[KEY_IDX] != UNLOCK_KEY);
  assign genFlag   = words[CFG_IDX][GEN_BIT];
  assign sizeField = words[CFG_IDX][SIZE_FIELD_W-1:0];

endmodule

// File: rtl/memcfg_sizedec.sv
module memcfg_sizedec
  import memcfg_pkg::*;
#(
  parameter int SIZE_W      = 16,
  parameter int BASE_OLD_MB = 64,
  parameter int BASE_NEW_MB = 128
) (
  input  logic                    genFlag,
  input  logic [SIZE_FIELD_W-1:0] sizeField,
  output logic [SIZE_W-1:0]       memSizeMb
);

  localparam logic [SIZE_W-1:0] OldBase = SIZE_W'(BASE_OLD_MB);
  localparam logic [SIZE_W-1:0] NewBase = SIZE_W'(BASE_NEW_MB);

  logic [SIZE_W-1:0] base;

  assign base      = genFlag ? NewBase : OldBase;
  assign memSizeMb = base << sizeField;

endmodule

// File: rtl/memcfg_keyguard.sv
module memcfg_keyguard
  import memcfg_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                SIZE_W      = 16,
  parameter int                BASE_OLD_MB = 64,
  parameter int                BASE_NEW_MB = 128,
  parameter logic [31:0]       CFG_RESET   = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [3:0]        pstrb,
  output logic              pready,
  output logic [31:0]       prdata,
  output logic              pslverr,
  output logic              lockedO,
  output logic [SIZE_W-1:0] memSizeMb
);

  strobe_t                 strobes;
  logic                    genFlag;
  logic [SIZE_FIELD_W-1:0] sizeField;

  memcfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pstrb   (pstrb),
    .lockedI (lockedO),
    .strobes (strobes),
    .pready  (pready),
    .pslverr (pslverr)
  );

  memcfg_regs #(.CFG_RESET(CFG_RESET)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .lockedO   (lockedO),
    .genFlag   (genFlag),
    .sizeField (sizeField)
  );

  memcfg_sizedec #(
    .SIZE_W      (SIZE_W),
    .BASE_OLD_MB (BASE_OLD_MB),
    .BASE_NEW_MB (BASE_NEW_MB)
  ) u_dec (
    .genFlag   (genFlag),
    .sizeField (sizeField),
    .memSizeMb (memSizeMb)
  );

endmodule

// File: rtl/memcfg_keyguard_chk.sv
module memcfg_keyguard_chk #(
  parameter int ADDR_W = 12,
  parameter int SIZE_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [3:0]        pstrb,
  input logic              pready,
  input logic [31:0]       prdata,
  input logic              pslverr,
  input logic              lockedO,
  input logic [SIZE_W-1:0] memSizeMb
);

  localparam logic [ADDR_W-1:0] KeyOff = '0;
  localparam logic [ADDR_W-1:0] CfgOff = ADDR_W'(4);
  localparam logic [ADDR_W-3:0] FirstFree = (ADDR_W-2)'(2);
  localparam logic [31:0] Magic = 32'hFC60_0309;

  logic acc;
  logic goodWr;
  assign acc    = psel & penable;
  assign goodWr = acc & pwrite & (pstrb == 4'hF);

  // R9: every transfer completes in its access phase
  a_r9_always_ready: assert property (@(posedge clk) disable iff (!rstN)
    acc |-> pready);

  // R3: locked configuration write is flagged and has no effect
  a_r3_locked_cfg_err: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && paddr == CfgOff && lockedO) |-> pslverr);
  a_r3_locked_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && paddr == CfgOff && lockedO) |=> ($stable(memSizeMb) && lockedO));

  // R2: lock state follows the key written
  a_r2_unlock_on_magic: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && paddr == KeyOff && pwdata == Magic) |=> !lockedO);
  a_r2_relock_on_other: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && paddr == KeyOff && pwdata != Magic) |=> lockedO);

  // R7: out-of-range reads return zero with an error
  a_r7_oor_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !pwrite && paddr[1:0] == 2'b00 && paddr[ADDR_W-1:2] >= FirstFree)
      |-> (pslverr && prdata == 32'h0));

  // R8: misaligned accesses are flagged and change nothing
  a_r8_misaligned_err: assert property (@(posedge clk) disable iff (!rstN)
    (acc && paddr[1:0] != 2'b00) |-> pslverr);
  a_r8_misaligned_hold: assert property (@(posedge clk) disable iff (!rstN)
    (acc && paddr[1:0] != 2'b00) |=> ($stable(lockedO) && $stable(memSizeMb)));

  // R5 and R6: decoded size is always a single power of two
  a_r5_size_pow2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(memSizeMb) == 1);

endmodule

bind memcfg_keyguard memcfg_keyguard_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/memcfg_keyguard_tb.sv
module memcfg_keyguard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic        pready;
  logic [31:0] prdata;
  logic        pslverr;
  logic        lockedO;
  logic [15:0] memSizeMb;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  memcfg_keyguard u_dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .pready(pready),
    .prdata(prdata), .pslverr(pslverr), .lockedO(lockedO), .memSizeMb(memSizeMb)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic        expErr;
    logic [31:0] expRd;
    logic        expLocked;
    logic [15:0] expSize;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h004, 32'h0,         4'hF, 1'b0, 32'h2,         1'b1, 16'd256,  8'd4 },  // R4
    '{1'b1, 12'h004, 32'h3,         4'hF, 1'b1, 32'h0,         1'b1, 16'd256,  8'd3 },  // R3
    '{1'b0, 12'h004, 32'h0,         4'hF, 1'b0, 32'h2,         1'b1, 16'd256,  8'd3 },  // R3
    '{1'b1, 12'h000, 32'hFC600309,  4'hF, 1'b0, 32'h0,         1'b0, 16'd256,  8'd2 },  // R2
    '{1'b0, 12'h000, 32'h0,         4'hF, 1'b0, 32'hFC600309,  1'b0, 16'd256,  8'd1 },  // R1
    '{1'b1, 12'h004, 32'h3,         4'hF, 1'b0, 32'h0,         1'b0, 16'd512,  8'd5 },  // R5
    '{1'b0, 12'h004, 32'h0,         4'hF, 1'b0, 32'h3,         1'b0, 16'd512,  8'd10},  // R10
    '{1'b1, 12'h004, 32'h0,         4'hF, 1'b0, 32'h0,         1'b0, 16'd64,   8'd5 },  // R5
    '{1'b1, 12'h004, 32'h1,         4'hF, 1'b0, 32'h0,         1'b0, 16'd128,  8'd5 },  // R5
    '{1'b1, 12'h004, 32'h10000000,  4'hF, 1'b0, 32'h0,         1'b0, 16'd128,  8'd6 },  // R6
    '{1'b1, 12'h004, 32'h10000001,  4'hF, 1'b0, 32'h0,         1'b0, 16'd256,  8'd6 },  // R6
    '{1'b1, 12'h004, 32'h10000003,  4'hF, 1'b0, 32'h0,         1'b0, 16'd1024, 8'd6 },  // R6
    '{1'b1, 12'h008, 32'hDEADBEEF,  4'hF, 1'b1, 32'h0,         1'b0, 16'd1024, 8'd7 },  // R7
    '{1'b0, 12'h008, 32'h0,         4'hF, 1'b1, 32'h0,         1'b0, 16'd1024, 8'd7 },  // R7
    '{1'b0, 12'hFFC, 32'h0,         4'hF, 1'b1, 32'h0,         1'b0, 16'd1024, 8'd7 },  // R7
    '{1'b1, 12'h006, 32'h0,         4'hF, 1'b1, 32'h0,         1'b0, 16'd1024, 8'd8 },  // R8
    '{1'b1, 12'h004, 32'h0,         4'h3, 1'b1, 32'h0,         1'b0, 16'd1024, 8'd8 },  // R8
    '{1'b0, 12'h005, 32'h0,         4'hF, 1'b1, 32'h0,         1'b0, 16'd1024, 8'd8 },  // R8
    '{1'b1, 12'h001, 32'h0,         4'hF, 1'b1, 32'h0,         1'b0, 16'd1024, 8'd8 },  // R8
    '{1'b0, 12'h004, 32'h0,         4'hF, 1'b0, 32'h10000003,  1'b0, 16'd1024, 8'd10},  // R10
    '{1'b1, 12'h000, 32'h12345678,  4'hF, 1'b0, 32'h0,         1'b1, 16'd1024, 8'd2 },  // R2
    '{1'b0, 12'h000, 32'h0,         4'hF, 1'b0, 32'h12345678,  1'b1, 16'd1024, 8'd1 },  // R1
    '{1'b1, 12'h004, 32'h2,         4'hF, 1'b1, 32'h0,         1'b1, 16'd1024, 8'd3 },  // R3
    '{1'b1, 12'h000, 32'hFC600308,  4'hF, 1'b0, 32'h0,         1'b1, 16'd1024, 8'd2 },  // R2
    '{1'b1, 12'h004, 32'h0,         4'hF, 1'b1, 32'h0,         1'b1, 16'd1024, 8'd3 },  // R3
    '{1'b1, 12'h000, 32'hFC600309,  4'hF, 1'b0, 32'h0,         1'b0, 16'd1024, 8'd2 },  // R2
    '{1'b1, 12'h004, 32'h10000002,  4'hF, 1'b0, 32'h0,         1'b0, 16'd512,  8'd10}   // R10
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One APB transfer; outputs sampled mid access phase, inputs idle at the next negedge
  task automatic apb(input logic wr, input logic [11:0] addr, input logic [31:0] data,
                     input logic [3:0] strb, output logic [31:0] rd,
                     output logic err, output logic rdy);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = data; pstrb = strb;
    @(negedge clk);
    penable = 1'b1;
    #5;
    rd = prdata; err = pslverr; rdy = pready;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic err;
    logic rdy;
    string tag;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4: reset state at the ports
    check("R4", "lockedO", 32'(lockedO), 32'd1);
    check("R4", "memSizeMb", 32'(memSizeMb), 32'd256);
    apb(1'b0, 12'h000, 32'h0, 4'hF, rd, err, rdy);
    check("R4", "key read", rd, 32'h0);
    check("R4", "key read err", 32'(err), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d", TBL[i].req);
      apb(TBL[i].wr, TBL[i].addr, TBL[i].data, TBL[i].strb, rd, err, rdy);
      check("R9", $sformatf("pready v%0d", i), 32'(rdy), 32'd1);
      check(tag, $sformatf("pslverr v%0d", i), 32'(err), 32'(TBL[i].expErr));
      if (!TBL[i].wr) check(tag, $sformatf("prdata v%0d", i), rd, TBL[i].expRd);
      check(tag, $sformatf("lockedO v%0d", i), 32'(lockedO), 32'(TBL[i].expLocked));
      check(tag, $sformatf("memSizeMb v%0d", i), 32'(memSizeMb), 32'(TBL[i].expSize));
    end

    // R1: key write accepted while locked (relock then overwrite)
    apb(1'b1, 12'h000, 32'hA5A5_0001, 4'hF, rd, err, rdy);
    apb(1'b1, 12'h000, 32'h0BAD_F00D, 4'hF, rd, err, rdy);
    check("R1", "locked key write err", 32'(err), 32'd0);
    apb(1'b0, 12'h000, 32'h0, 4'hF, rd, err, rdy);
    check("R1", "key readback", rd, 32'h0BAD_F00D);

    // R4: reset in mid-run restores the preload and relocks
    apb(1'b1, 12'h000, 32'hFC60_0309, 4'hF, rd, err, rdy);
    apb(1'b1, 12'h004, 32'h1000_0003, 4'hF, rd, err, rdy);
    check("R10", "size before reset", 32'(memSizeMb), 32'd1024);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R4", "lockedO after reset", 32'(lockedO), 32'd1);
    check("R4", "size after reset", 32'(memSizeMb), 32'd256);
    apb(1'b0, 12'h004, 32'h0, 4'hF, rd, err, rdy);
    check("R4", "cfg after reset", rd, 32'h2);
    apb(1'b0, 12'h000, 32'h0, 4'hF, rd, err, rdy);
    check("R4", "key after reset", rd, 32'h0);

    summary();
  end

endmodule